// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at the state of a bank of interrupt lines and picks the single best one to signal to a target. For every line it receives a pending bit, an enable bit, an active bit, a two-bit group code, an eight-bit priority, four eight-bit routing fields and a route-to-any flag. It also receives one global enable per group. Together these come from the register bank that holds the interrupt configuration.

A line can win only if it is pending, enabled, not active, and its group is globally enabled. Among those lines, the lowest numeric priority wins. When two lines have the same priority, the lower ID wins. The result is registered, so it appears one clock after the inputs it was computed from. It gives:
- the winner's ID, priority and group;
- a valid flag;
- either a packed 32-bit target affinity or a flag saying any eligible target may take the interrupt.

The inputs are level state, not a stream. The output is a status word that is refreshed on every clock and is never held back. There is no valid/ready handshake and no back-pressure: a consumer samples the word whenever it needs it.

Top module: `hpp_sel`

## Requirements
- R1: A line is a candidate only when its pending bit is 1, its enable bit is 1 and its active bit is 0, and its group is globally enabled (see R2).
- R2: Group codes are 0, 1 and 2. Each one is gated by the global group enable bit of the same index (bit 0, 1, 2). Code 3 is never a candidate.
- R3: Among the candidates, the line with the numerically lowest priority value wins.
- R4: When several candidates share the lowest priority, the one with the lowest line index wins.
- R5: The reported ID equals ID_BASE plus the line index (ID_BASE defaults to 32). The reported priority and group are those of the winning line, and valid is 1.
- R6: With no candidate, the outputs are: valid 0, ID 1023, priority 0xFF, group 0, route-to-any 0 and affinity 0.
- R7: If the winner's route-to-any flag is 1, the route-to-any output is 1 and the affinity output is 0.
- R8: Otherwise the affinity output packs the winner's routing fields as Aff3 in bits 31:24, Aff2 in 23:16, Aff1 in 15:8 and Aff0 in 7:0. Each field's input is a flat vector with line i in bits [8i+7:8i].
- R9: The outputs change exactly one clock edge after the inputs change, and hold their value between edges.
- R10: While reset is asserted, the outputs take the idle values of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_IRQ | Pending bit per line |
| en_i | input | N_IRQ | Enable bit per line |
| act_i | input | N_IRQ | Active bit per line |
| grp_i | input | 2*N_IRQ | Group code per line, line i in [2i+1:2i] |
| prio_i | input | 8*N_IRQ | Priority per line, line i in [8i+7:8i] |
| grp_en_i | input | 3 | Global enable per group code |
| any_i | input | N_IRQ | Route-to-any flag per line |
| aff3_i | input | 8*N_IRQ | Routing field Aff3 per line |
| aff2_i | input | 8*N_IRQ | Routing field Aff2 per line |
| aff1_i | input | 8*N_IRQ | Routing field Aff1 per line |
| aff0_i | input | 8*N_IRQ | Routing field Aff0 per line |
| win_vld_o | output | 1 | A winner exists |
| win_id_o | output | 10 | Winner ID, 1023 when none |
| win_prio_o | output | 8 | Winner priority |
| win_grp_o | output | 2 | Winner group code |
| win_any_o | output | 1 | Winner may go to any eligible target |
| win_aff_o | output | 32 | Packed target affinity of the winner |

## Verification
The hardest case to reach is a tie at the lowest priority between lines that are eligible only because of a particular mix of group enables, while lower-index lines at that same priority are masked by their active bit or by a disabled group. Uniform random priorities almost never produce this. The bench therefore draws most priorities from a set of only four values, sweeps all eight group-enable combinations, and biases the pending, enable and active bits so that a few lines survive in each vector. Directed vectors then pin down the exact tie, the reserved group code and the route-to-any case.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int ID_W    = 10;
  localparam int PRIO_W  = 8;
  localparam int GRP_W   = 2;
  localparam int NUM_GRP = 3;
  localparam int AFF_W   = 8;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  typedef enum logic [GRP_W-1:0] {
    GRP_ZERO = 2'd0,
    GRP_ONE  = 2'd1,
    GRP_TWO  = 2'd2,
    GRP_OFF  = 2'd3
  } grp_e;
endpackage

// File: rtl/hpp_elig.sv
module hpp_elig
  import hpp_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic [N_IRQ-1:0]       pend_i,
  input  logic [N_IRQ-1:0]       en_i,
  input  logic [N_IRQ-1:0]       act_i,
  input  logic [GRP_W*N_IRQ-1:0] grp_i,
  input  logic [NUM_GRP-1:0]     grp_en_i,
  output logic [N_IRQ-1:0]       elig_o
);
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic grp_ok;
    always_comb begin
      case (grp_e'(grp_i[i*GRP_W +: GRP_W]))
        GRP_ZERO: grp_ok = grp_en_i[0];
        GRP_ONE:  grp_ok = grp_en_i[1];
        GRP_TWO:  grp_ok = grp_en_i[2];
        default:  grp_ok = 1'b0;
      endcase
    end
    assign elig_o[i] = pend_i[i] & en_i[i] & ~act_i[i] & grp_ok;
  end
endmodule

// File: rtl/hpp_scan.sv
module hpp_scan
  import hpp_pkg::*;
#(
  parameter int N_IRQ = 32,
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        elig_i,
  input  logic [PRIO_W*N_IRQ-1:0] prio_i,
  output logic                    best_vld_o,
  output logic [IW-1:0]           best_idx_o,
  output logic [PRIO_W-1:0]       best_prio_o
);
  // Ascending scan with strict less-than: an equal priority never
  // displaces an earlier (lower-index) holder.
  always_comb begin
    best_vld_o  = 1'b0;
    best_idx_o  = '0;
    best_prio_o = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (elig_i[i] && (!best_vld_o || prio_i[i*PRIO_W +: PRIO_W] < best_prio_o)) begin
        best_vld_o  = 1'b1;
        best_idx_o  = IW'(i);
        best_prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_pick_elig_R1: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld_o |-> elig_i[best_idx_o]);
  assert_none_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !best_vld_o |-> (elig_i == '0));
endmodule

// File: rtl/hpp_route.sv
module hpp_route
  import hpp_pkg::*;
#(
  parameter int N_IRQ = 32,
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                   vld_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [N_IRQ-1:0]       any_i,
  input  logic [AFF_W*N_IRQ-1:0] aff3_i,
  input  logic [AFF_W*N_IRQ-1:0] aff2_i,
  input  logic [AFF_W*N_IRQ-1:0] aff1_i,
  input  logic [AFF_W*N_IRQ-1:0] aff0_i,
  output logic                   any_o,
  output logic [4*AFF_W-1:0]     aff_o
);
  logic sel_any;
  assign sel_any = vld_i & any_i[idx_i];

  always_comb begin
    any_o = sel_any;
    aff_o = '0;
    if (vld_i && !sel_any) begin
      aff_o = {aff3_i[int'(idx_i)*AFF_W +: AFF_W], aff2_i[int'(idx_i)*AFF_W +: AFF_W],
               aff1_i[int'(idx_i)*AFF_W +: AFF_W], aff0_i[int'(idx_i)*AFF_W +: AFF_W]};
    end
  end
endmodule

// File: rtl/hpp_sel.sv
module hpp_sel
  import hpp_pkg::*;
#(
  parameter int N_IRQ   = 32,
  parameter int ID_BASE = 32,
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        pend_i,
  input  logic [N_IRQ-1:0]        en_i,
  input  logic [N_IRQ-1:0]        act_i,
  input  logic [GRP_W*N_IRQ-1:0]  grp_i,
  input  logic [PRIO_W*N_IRQ-1:0] prio_i,
  input  logic [NUM_GRP-1:0]      grp_en_i,
  input  logic [N_IRQ-1:0]        any_i,
  input  logic [AFF_W*N_IRQ-1:0]  aff3_i,
  input  logic [AFF_W*N_IRQ-1:0]  aff2_i,
  input  logic [AFF_W*N_IRQ-1:0]  aff1_i,
  input  logic [AFF_W*N_IRQ-1:0]  aff0_i,
  output logic                    win_vld_o,
  output logic [ID_W-1:0]         win_id_o,
  output logic [PRIO_W-1:0]       win_prio_o,
  output logic [GRP_W-1:0]        win_grp_o,
  output logic                    win_any_o,
  output logic [4*AFF_W-1:0]      win_aff_o
);
  logic [N_IRQ-1:0]   elig;
  logic               c_vld;
  logic [IW-1:0]      c_idx;
  logic [PRIO_W-1:0]  c_prio;
  logic               c_any;
  logic [4*AFF_W-1:0] c_aff;

  hpp_elig #(.N_IRQ(N_IRQ)) elig_i (
    .pend_i(pend_i), .en_i(en_i), .act_i(act_i), .grp_i(grp_i),
    .grp_en_i(grp_en_i), .elig_o(elig)
  );

  hpp_scan #(.N_IRQ(N_IRQ)) scan_i (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .prio_i(prio_i),
    .best_vld_o(c_vld), .best_idx_o(c_idx), .best_prio_o(c_prio)
  );

  hpp_route #(.N_IRQ(N_IRQ)) route_i (
    .vld_i(c_vld), .idx_i(c_idx), .any_i(any_i),
    .aff3_i(aff3_i), .aff2_i(aff2_i), .aff1_i(aff1_i), .aff0_i(aff0_i),
    .any_o(c_any), .aff_o(c_aff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_vld_o  <= 1'b0;
      win_id_o   <= ID_NONE;
      win_prio_o <= '1;
      win_grp_o  <= '0;
      win_any_o  <= 1'b0;
      win_aff_o  <= '0;
    end else if (c_vld) begin
      win_vld_o  <= 1'b1;
      win_id_o   <= ID_W'(ID_BASE) + ID_W'(c_idx);
      win_prio_o <= c_prio;
      win_grp_o  <= grp_i[int'(c_idx)*GRP_W +: GRP_W];
      win_any_o  <= c_any;
      win_aff_o  <= c_aff;
    end else begin
      win_vld_o  <= 1'b0;
      win_id_o   <= ID_NONE;
      win_prio_o <= '1;
      win_grp_o  <= '0;
      win_any_o  <= 1'b0;
      win_aff_o  <= '0;
    end
  end

  assert_vld_grp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (win_grp_o != GRP_OFF));
  assert_idle_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld_o |-> (win_id_o == ID_NONE && win_prio_o == '1 && win_aff_o == '0 && !win_any_o));
  assert_any_aff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_any_o |-> (win_vld_o && win_aff_o == '0));
  assert_id_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (win_id_o >= ID_W'(ID_BASE) && win_id_o < ID_W'(ID_BASE + N_IRQ)));
endmodule

// File: tb/hpp_sel_tb_top.sv
module hpp_sel_tb_top;
  localparam int N = 8;
  localparam int BASE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   pend = '0, en = '0, act = '0, anyv = '0;
  logic [2*N-1:0] grp = '0;
  logic [8*N-1:0] prio = '0, a3 = '0, a2 = '0, a1 = '0, a0 = '0;
  logic [2:0]     gen = '0;

  logic        vld, wany;
  logic [9:0]  id;
  logic [7:0]  wprio;
  logic [1:0]  wgrp;
  logic [31:0] waff;

  hpp_sel #(.N_IRQ(N), .ID_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .act_i(act),
    .grp_i(grp), .prio_i(prio), .grp_en_i(gen), .any_i(anyv),
    .aff3_i(a3), .aff2_i(a2), .aff1_i(a1), .aff0_i(a0),
    .win_vld_o(vld), .win_id_o(id), .win_prio_o(wprio), .win_grp_o(wgrp),
    .win_any_o(wany), .win_aff_o(waff)
  );

  int n_run = 0;
  int n_bad = 0;
  logic [53:0] exp_w;

  // Expected output word {vld, id, prio, grp, any, aff}, from the requirements.
  function automatic logic [53:0] ref_scan();
    logic ok;
    int best;
    best = -1;
    for (int i = 0; i < N; i++) begin
      ok = pend[i] && en[i] && !act[i] && grp[2*i +: 2] != 2'd3 && gen[grp[2*i +: 2]];
      if (ok && (best < 0 || prio[8*i +: 8] < prio[8*best +: 8])) best = i;
    end
    if (best < 0) return {1'b0, 10'd1023, 8'hFF, 2'd0, 1'b0, 32'd0};
    if (anyv[best])
      return {1'b1, 10'(BASE + best), prio[8*best +: 8], grp[2*best +: 2], 1'b1, 32'd0};
    return {1'b1, 10'(BASE + best), prio[8*best +: 8], grp[2*best +: 2], 1'b0,
            a3[8*best +: 8], a2[8*best +: 8], a1[8*best +: 8], a0[8*best +: 8]};
  endfunction

  task automatic chk(input string req, input logic [53:0] expv);
    logic [53:0] act_w;
    act_w = {vld, id, wprio, wgrp, wany, waff};
    n_run++;
    if (act_w !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_w, expv);
    end
  endtask

  // Inputs set at a falling edge; result checked at the next falling edge.
  task automatic step(input string req);
    exp_w = ref_scan();
    @(negedge clk);
    chk(req, exp_w);
  endtask

  task automatic clear_all();
    pend = '0; en = '0; act = '0; anyv = '0; grp = '0; prio = '0;
    a3 = '0; a2 = '0; a1 = '0; a0 = '0; gen = '0;
  endtask

  task automatic rand_fill(input bit narrow);
    for (int i = 0; i < N; i++) begin
      pend[i] = ($urandom % 4) != 0;
      en[i]   = ($urandom % 4) != 0;
      act[i]  = ($urandom % 5) == 0;
      anyv[i] = ($urandom % 3) == 0;
      grp[2*i +: 2] = 2'($urandom);
      prio[8*i +: 8] = narrow ? 8'($urandom % 4) * 8'h40 : 8'($urandom);
      a3[8*i +: 8] = 8'($urandom); a2[8*i +: 8] = 8'($urandom);
      a1[8*i +: 8] = 8'($urandom); a0[8*i +: 8] = 8'($urandom);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : main
    logic [53:0] old_w;
    // R10: idle values held during reset, with candidate-looking inputs applied
    pend = '1; en = '1; gen = 3'b111;
    repeat (3) @(negedge clk);
    chk("R10", {1'b0, 10'd1023, 8'hFF, 2'd0, 1'b0, 32'd0});
    rst_n = 1'b1;
    clear_all();
    step("R6");

    // R1: active and disabled lines are skipped
    clear_all(); gen = 3'b111;
    pend = 8'b0000_0111; en = 8'b0000_0110; act = 8'b0000_0010;
    prio[0 +: 8] = 8'h00; prio[8 +: 8] = 8'h00; prio[16 +: 8] = 8'h70;
    step("R1");

    // R2: group 3 never wins even with all enables; disabled group skipped
    clear_all(); gen = 3'b111;
    pend = 8'b11; en = 8'b11; grp[1:0] = 2'd3; grp[3:2] = 2'd1;
    prio[0 +: 8] = 8'h00; prio[8 +: 8] = 8'hC0;
    step("R2");
    gen = 3'b101;
    step("R2");

    // R3 and R4: lowest value wins, ties go to the lower index
    clear_all(); gen = 3'b111; pend = '1; en = '1;
    for (int i = 0; i < N; i++) prio[8*i +: 8] = 8'h80;
    prio[8*5 +: 8] = 8'h20; prio[8*6 +: 8] = 8'h20; prio[8*7 +: 8] = 8'h10;
    step("R3");
    act[7] = 1'b1;
    step("R4");

    // R7 and R8: route-to-any and affinity packing
    clear_all(); gen = 3'b001; pend[3] = 1'b1; en[3] = 1'b1;
    a3[24 +: 8] = 8'hA3; a2[24 +: 8] = 8'hB2; a1[24 +: 8] = 8'hC1; a0[24 +: 8] = 8'hD0;
    step("R8");
    chk("R8", {1'b1, 10'd35, 8'h00, 2'd0, 1'b0, 32'hA3B2C1D0});
    anyv[3] = 1'b1;
    step("R7");

    // R9: output still holds the old word just after inputs change
    old_w = exp_w;
    anyv[3] = 1'b0; prio[24 +: 8] = 8'h44;
    #2 chk("R9", old_w);
    step("R9");

    // R5: sweep every group-enable mix with random and tie-heavy state
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 300; k++) begin
        gen = 3'(g);
        rand_fill(k % 3 != 0);
        exp_w = ref_scan();
        step(exp_w[53] ? "R5" : "R6");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule